// File: doc/BRIEF.md
# Two-Level Hardware Page-Table Walker

This block resolves translation-cache misses without software help. When the translation cache reports a miss, the walker captures the virtual address and the current page-table base. It then reads one table entry per level through a single request/response memory port. Each entry read must have its present bit set before the walk moves on. A present directory entry supplies the base of the next table. A present leaf entry supplies the physical frame number. The frame is returned to the translation cache together with the virtual page number and the full physical address.

A clear present bit at any level ends the walk at once. The block then pulses a fault indication carrying the faulting virtual address, and no fill is produced. Only one walk is in flight at a time, and a busy output tells the miss source when a new miss may be offered. With the default parameters, a 32-bit virtual address is split, from the top bit down, into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. Entries are 32 bits wide.

Top module: `ptw_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are all 0.
- R2: A miss is accepted on a clock edge where `miss_valid` is 1 and `busy` is 0. A `miss_valid` offered while `busy` is 1 is ignored: the running walk's results are unchanged, and no second walk follows.
- R3: The first read address is the page-table base sampled at acceptance plus four times the directory index (vaddr bits 31:22). Later changes of `root_base` do not affect the walk.
- R4: When the directory entry is present, the second read address is that entry's bits 31:12 followed by twelve zero bits, plus four times the table index (vaddr bits 21:12).
- R5: A read request keeps `mem_req_valid` high and `mem_req_addr` stable until the cycle in which `mem_req_ready` is 1.
- R6: `mem_rsp_valid` pulses that arrive while no read is outstanding have no effect. In particular, in the idle state they raise neither busy, fill nor fault.
- R7: When the leaf entry has bit 0 (present) set, `fill_valid` pulses. In that cycle `fill_vpn` is vaddr bits 31:12, `fill_pfn` is entry bits 31:12, and `fill_paddr` is the frame followed by vaddr bits 11:0. Entry bits 11:1 are ignored.
- R8: When the directory entry has bit 0 clear, `fault_valid` pulses with `fault_vaddr` equal to the missed address. No second read is issued and no fill is produced.
- R9: When the directory entry is present but the leaf entry has bit 0 clear, `fault_valid` pulses with the missed address and no fill is produced.
- R10: `fill_valid` and `fault_valid` are each high for exactly one cycle per walk and are never high together.
- R11: `busy` is 1 from the cycle after acceptance through the fill or fault cycle, and 0 in the cycle after it.
- R12: The fill or fault pulse appears N·(S+1+L) cycles after acceptance. N is the number of levels read, S is the number of cycles each request waits for ready, and L is the number of cycles from the request handshake to the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Translation miss offered |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Page-table base register value |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| fill_valid | output | 1 | One-cycle fill to the translation cache |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_pfn | output | 20 | Physical frame number of the fill |
| fill_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_vaddr | output | 32 | Faulting virtual address |

## Verification
`busy` rises one cycle after acceptance. Each level then costs S+1+L cycles, so the outcome pulse falls due exactly N·(S+1+L) cycles after acceptance, with N set to 1 or 2 by the directory entry's present bit. The bench's memory model drives ready and response at the falling edge with a chosen stall S and latency L, and counts falling edges from acceptance until the pulse. The outputs are sampled in that cycle, and busy, fill and fault are sampled again one cycle later to confirm the pulse has ended.

// File: rtl/ptw_pkg.sv
// Package: shared types of the page-table walker.
// Assumes: nothing beyond IEEE 1800-2017.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FILL,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/ptw_va_split.sv
// Module: ptw_va_split
// Picks the table index used at the current walk level out of the virtual
// address. Level 0 takes the topmost index field.
// Assumes: lvl is always below LEVELS.
module ptw_va_split #(
    parameter int LEVELS = 2,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int VA_W   = OFF_W + LEVELS * IDX_W,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] field [LEVELS];

    // One slice per level, highest field first.
    for (genvar k = 0; k < LEVELS; k++) begin : g_field
        assign field[k] = vaddr[VA_W-1-k*IDX_W -: IDX_W];
    end

    // Select the field of the active level.
    always_comb idx = field[lvl];

endmodule

// File: rtl/ptw_entry_addr.sv
// Module: ptw_entry_addr
// Forms the byte address of a table entry from the table base and the index.
// Assumes: entries are PTE_W bits, and PTE_W/8 is a power of two.
module ptw_entry_addr #(
    parameter int AW    = 32,
    parameter int IDX_W = 10,
    parameter int PTE_W = 32,
    parameter int SHIFT = $clog2(PTE_W / 8)
) (
    input  logic [AW-1:0]    table_base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    entry_addr
);

    // Base plus index scaled by the entry size in bytes.
    always_comb entry_addr = table_base + (AW'(idx) << SHIFT);

endmodule

// File: rtl/ptw_seq.sv
// Module: ptw_seq
// Walk sequencer. It captures a miss, issues one entry read per level, checks
// the present bit (bit 0) of each entry, and ends in a one-cycle fill or
// fault state.
// Assumes: one read is outstanding at most, and responses come in order.
module ptw_seq
    import ptw_pkg::*;
#(
    parameter int LEVELS = 2,
    parameter int OFF_W  = 12,
    parameter int VA_W   = 32,
    parameter int PTE_W  = 32,
    parameter int FR_W   = PTE_W - OFF_W,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [PTE_W-1:0]  root_base,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic [VA_W-1:0]   vaddr_q,
    output logic [PTE_W-1:0]  table_base_q,
    output logic [LVL_W-1:0]  lvl_q,
    output logic [FR_W-1:0]   frame_q,
    output logic              req_valid,
    output logic              busy,
    output logic              fill_pulse,
    output logic              fault_pulse
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e state_q;
    logic        present;
    logic [FR_W-1:0] rsp_frame;
    logic        unused_attr_bits;

    // Split the returned entry into present bit and frame.
    always_comb begin
        present   = mem_rsp_data[0];
        rsp_frame = mem_rsp_data[PTE_W-1:OFF_W];
    end
    assign unused_attr_bits = ^mem_rsp_data[OFF_W-1:1];

    // Walk state, level counter and captured walk context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            vaddr_q      <= '0;
            table_base_q <= '0;
            lvl_q        <= '0;
            frame_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        vaddr_q      <= miss_vaddr;
                        table_base_q <= root_base;
                        lvl_q        <= '0;
                        state_q      <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!present) begin
                            state_q <= ST_FAULT;
                        end else if (lvl_q == LAST_LVL) begin
                            frame_q <= rsp_frame;
                            state_q <= ST_FILL;
                        end else begin
                            table_base_q <= {rsp_frame, {OFF_W{1'b0}}};
                            lvl_q        <= lvl_q + 1'b1;
                            state_q      <= ST_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode state into the handshake and pulse outputs.
    always_comb begin
        req_valid   = (state_q == ST_REQ);
        busy        = (state_q != ST_IDLE);
        fill_pulse  = (state_q == ST_FILL);
        fault_pulse = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/ptw_engine.sv
// Module: ptw_engine (top)
// Hardware page-table walker. It turns a translation miss into a chain of
// dependent entry reads and returns either a fill or a page fault.
// Assumes: table bases are aligned to 2**OFF_W bytes, and the memory port
// answers each accepted request with exactly one response.
module ptw_engine #(
    parameter int LEVELS = 2,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int PTE_W  = 32,
    parameter int VA_W   = OFF_W + LEVELS * IDX_W,
    parameter int VPN_W  = VA_W - OFF_W,
    parameter int FR_W   = PTE_W - OFF_W,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [PTE_W-1:0]  root_base,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PTE_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              fill_valid,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [FR_W-1:0]   fill_pfn,
    output logic [PTE_W-1:0]  fill_paddr,
    output logic              fault_valid,
    output logic [VA_W-1:0]   fault_vaddr
);

    logic [VA_W-1:0]  vaddr_q;
    logic [PTE_W-1:0] table_base_q;
    logic [LVL_W-1:0] lvl_q;
    logic [FR_W-1:0]  frame_q;
    logic [IDX_W-1:0] cur_idx;

    ptw_seq #(
        .LEVELS(LEVELS), .OFF_W(OFF_W), .VA_W(VA_W), .PTE_W(PTE_W),
        .FR_W(FR_W), .LVL_W(LVL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_vaddr   (miss_vaddr),
        .root_base    (root_base),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .vaddr_q      (vaddr_q),
        .table_base_q (table_base_q),
        .lvl_q        (lvl_q),
        .frame_q      (frame_q),
        .req_valid    (mem_req_valid),
        .busy         (busy),
        .fill_pulse   (fill_valid),
        .fault_pulse  (fault_valid)
    );

    ptw_va_split #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .VA_W(VA_W), .LVL_W(LVL_W)
    ) u_split (
        .vaddr(vaddr_q),
        .lvl  (lvl_q),
        .idx  (cur_idx)
    );

    ptw_entry_addr #(
        .AW(PTE_W), .IDX_W(IDX_W), .PTE_W(PTE_W)
    ) u_addr (
        .table_base(table_base_q),
        .idx       (cur_idx),
        .entry_addr(mem_req_addr)
    );

    // Fill and fault payloads come from the captured walk context.
    always_comb begin
        fill_vpn    = vaddr_q[VA_W-1:OFF_W];
        fill_pfn    = frame_q;
        fill_paddr  = {frame_q, vaddr_q[OFF_W-1:0]};
        fault_vaddr = vaddr_q;
    end

endmodule

// File: rtl/ptw_engine_chk.sv
// Module: ptw_engine_chk
// Protocol and pulse properties of the walker, attached by bind.
// Assumes: synchronous active-low reset.
module ptw_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        miss_valid,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        fill_valid,
    input logic        fault_valid
);

    a_r2_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> busy);

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req_valid || fill_valid || fault_valid));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

    a_r10_fill_once: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    a_r10_fault_once: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> !busy);

endmodule

bind ptw_engine ptw_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .fill_valid   (fill_valid),
    .fault_valid  (fault_valid)
);

// File: tb/ptw_engine_bench.sv
// Bench for ptw_engine: sweeps directory and table indices over a computed
// page table, with several memory stall and latency settings.
module ptw_engine_bench;

    localparam logic [31:0] ROOT = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [31:0] miss_vaddr;
    logic [31:0] root_base;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_pfn;
    logic [31:0] fill_paddr;
    logic        fault_valid;
    logic [31:0] fault_vaddr;

    int total = 0;
    int bad   = 0;
    int cfg_stall = 0;
    int cfg_lat   = 1;
    int nreq = 0;
    logic [31:0] req_log [4];
    logic inj = 1'b0;

    always #5 clk = ~clk;

    ptw_engine u_ptw_engine (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
        .root_base(root_base), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_paddr(fill_paddr), .fault_valid(fault_valid), .fault_vaddr(fault_vaddr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Table contents computed from the address.
    function automatic logic [31:0] pte_of(input logic [31:0] a);
        int d, t;
        logic p;
        logic [19:0] fr;
        if (a >= 32'h0020_0000) begin
            d  = int'(a >> 12) - 32'h200;
            t  = int'(a[11:0]) >> 2;
            p  = ((t % 5) != 4);
            fr = 20'((d * 7 + t * 13 + 32'h4_0000) & 32'hF_FFFF);
        end else begin
            d  = int'((a - ROOT) >> 2);
            p  = ((d % 3) != 2);
            fr = 20'(32'h200 + d);
        end
        return {fr, 11'h5A4, p};
    endfunction

    // Memory model: stall, handshake and delayed response at falling edges.
    initial begin
        int stall_left = 0;
        int cnt = 0;
        logic holding = 1'b0;
        logic [31:0] addr_l = '0;
        logic [31:0] hold_addr = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (inj) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_F001;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pte_of(addr_l);
                end
            end else if (mem_req_valid) begin
                if (!holding) begin
                    holding    = 1'b1;
                    hold_addr  = mem_req_addr;
                    stall_left = cfg_stall;
                end else begin
                    chk(mem_req_addr == hold_addr, "R5 addr held", mem_req_addr, hold_addr);
                end
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    mem_req_ready = 1'b1;
                    addr_l  = mem_req_addr;
                    cnt     = cfg_lat;
                    holding = 1'b0;
                    if (nreq < 4) req_log[nreq] = mem_req_addr;
                    nreq++;
                end
            end
        end
    end

    task automatic walk(input logic [31:0] va, input int s, input int l, input bit dup);
        int d = int'(va[31:22]);
        int t = int'(va[21:12]);
        int cyc = 0;
        int lv;
        logic [31:0] a1 = ROOT + 32'(d * 4);
        logic [31:0] e1 = pte_of(a1);
        logic [31:0] a2 = {e1[31:12], 12'h0} + 32'(t * 4);
        logic [31:0] e2 = pte_of(a2);
        bit exp_fault = !e1[0] || !e2[0];
        lv = e1[0] ? 2 : 1;
        cfg_stall = s;
        cfg_lat   = l;
        nreq      = 0;
        @(negedge clk);
        root_base  = ROOT;
        miss_vaddr = va;
        miss_valid = 1'b1;
        @(negedge clk);
        root_base = 32'hDEAD_0000;
        chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
        if (dup) miss_vaddr = va ^ 32'h0040_1000;
        else miss_valid = 1'b0;
        while (!(fill_valid || fault_valid) && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (!(fill_valid || fault_valid))
                chk(busy == 1'b1, "R11 busy during walk", 32'(busy), 32'd1);
        end
        miss_valid = 1'b0;
        chk(cyc == lv * (s + 1 + l), "R12 latency", 32'(cyc), 32'(lv * (s + 1 + l)));
        chk(nreq == lv, "R8 read count", 32'(nreq), 32'(lv));
        chk(req_log[0] == a1, "R3 first address", req_log[0], a1);
        if (e1[0]) chk(req_log[1] == a2, "R4 second address", req_log[1], a2);
        if (exp_fault) begin
            chk(fault_valid == 1'b1, e1[0] ? "R9 leaf fault" : "R8 dir fault",
                32'(fault_valid), 32'd1);
            chk(fault_vaddr == va, "R8 fault address", fault_vaddr, va);
            chk(fill_valid == 1'b0, "R10 no fill on fault", 32'(fill_valid), 32'd0);
        end else begin
            chk(fill_valid == 1'b1, "R7 fill", 32'(fill_valid), 32'd1);
            chk(fault_valid == 1'b0, "R10 no fault on fill", 32'(fault_valid), 32'd0);
            chk(fill_vpn == va[31:12], "R7 vpn", 32'(fill_vpn), 32'(va[31:12]));
            chk(fill_pfn == e2[31:12], "R7 pfn", 32'(fill_pfn), 32'(e2[31:12]));
            chk(fill_paddr == {e2[31:12], va[11:0]}, "R7 paddr", fill_paddr,
                {e2[31:12], va[11:0]});
        end
        @(negedge clk);
        chk(!fill_valid && !fault_valid, "R10 single pulse",
            32'({fill_valid, fault_valid}), 32'd0);
        chk(busy == 1'b0, dup ? "R2 second miss ignored" : "R11 busy drop", 32'(busy), 32'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog act=%0d exp=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Main sequence.
    initial begin
        rst_n      = 1'b0;
        miss_valid = 1'b0;
        miss_vaddr = '0;
        root_base  = ROOT;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 in reset",
            32'({busy, mem_req_valid, fill_valid, fault_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 after reset",
            32'({busy, mem_req_valid, fill_valid, fault_valid}), 32'd0);

        inj = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!busy && !fill_valid && !fault_valid, "R6 idle response",
                32'({busy, fill_valid, fault_valid}), 32'd0);
        end
        inj = 1'b0;
        @(negedge clk);
        chk(!busy && !fill_valid && !fault_valid, "R6 idle after response",
            32'({busy, fill_valid, fault_valid}), 32'd0);

        for (int d = 0; d < 1024; d += 31) begin
            for (int k = 0; k < 3; k++) begin
                int t = (d * 3 + k * 341 + k) % 1024;
                logic [31:0] va = {10'(d), 10'(t), 12'(d * 37 + k * 1001)};
                walk(va, (d + k) % 3, 1 + (d + 2 * k) % 3, (k == 1));
            end
        end
        walk({10'd1023, 10'd1023, 12'hFFF}, 0, 1, 1'b0);
        walk({10'd1, 10'd4, 12'h123}, 2, 3, 1'b0);
        walk({10'd2, 10'd0, 12'h000}, 1, 1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule